// File: doc/BRIEF.md
# Sprite Page Copy Engine with Half-Rate Alignment

This block moves one 256-byte page of CPU-visible memory into the sprite attribute store. It watches the CPU bus, and a CPU write of byte P to the trigger address 0x4014 starts a copy of addresses P*256 through P*256+255. While the copy runs, the block holds the CPU stalled through a halt output. Each byte is moved in two cycles: one cycle reads the source, and the next cycle writes the byte to the attribute store.

The block keeps its own free-running half-rate phase, and it brings that phase out so that the audio sample-fetch timer can share it. Before the copy starts there is always one dead cycle. A second dead cycle is added when the trigger write landed on an odd phase, so that the read/write pairs stay in step with the half-rate timebase. The stall therefore lasts 513 or 514 cycles.

An audio sample fetch may ask for the bus during a copy. It is granted two cycles, taken at a read boundary, and is not granted outside a copy.

Top module: `sdma_engine`

## Requirements
- R1: `phase_odd` is 0 in the first cycle after reset is released and inverts on every clock edge after that.
- R2: An idle-time bus write of byte P with `cpu_we` high and `cpu_addr` equal to 0x4014 starts a copy from page P. A write to any other address starts nothing.
- R3: `cpu_halt` rises in the cycle after the trigger write. When the trigger cycle has `phase_odd` equal to 0 and no sample fetch is granted, it stays high for exactly 513 cycles.
- R4: When the trigger cycle has `phase_odd` equal to 1 and no sample fetch is granted, `cpu_halt` stays high for exactly 514 cycles.
- R5: The copy makes 256 pairs in ascending order i = 0..255. In each pair, a cycle with `mem_rd` high and `mem_addr` = P*256+i is followed directly by a cycle with `spr_we` high, `spr_idx` = i, and `spr_wdata` equal to the byte read. The first halt cycle makes no access.
- R6: `xfer_done` is high for exactly one cycle, which is the first cycle in which `cpu_halt` is low again.
- R7: A sample request raised during a copy is granted with `smp_gnt` high for 2 consecutive cycles, placed before a read. Each grant lengthens the halt by exactly 2 cycles and leaves the copied data unchanged.
- R8: A sample request while idle gets no grant and does not raise `cpu_halt`.
- R9: Trigger writes made while a copy is running are ignored. The page and the length stay as they were, and no second copy follows.
- R10: Neither `mem_rd` nor `spr_we` is ever high while `cpu_halt` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Snooped CPU address |
| cpu_wdata | input | 8 | Snooped CPU write data |
| cpu_we | input | 1 | Snooped CPU write strobe |
| mem_addr | output | 16 | Source read address |
| mem_rd | output | 1 | Source read strobe; data returns the next cycle |
| mem_rdata | input | 8 | Source read data |
| spr_we | output | 1 | Attribute store write strobe |
| spr_idx | output | 8 | Attribute store index |
| spr_wdata | output | 8 | Attribute store write data |
| cpu_halt | output | 1 | CPU stall |
| xfer_done | output | 1 | One-cycle pulse when the stall ends |
| smp_req | input | 1 | Audio sample fetch request |
| smp_gnt | output | 1 | Audio sample fetch grant, 2 cycles |
| phase_odd | output | 1 | Shared half-rate phase, 1 on odd cycles |

## Verification
The hardest case to reach is a sample request that meets the copy at a chosen point, possibly twice, while the trigger also lands on an odd phase. The bench counts cycles from reset itself, so it can place the trigger write on a phase it chooses. It then raises the request at a random halt-cycle count and drops it on the first grant it sees, and it expects the length 513 + parity + 2 per grant. A stray trigger write injected in the middle of a copy covers the busy-ignore case within the same runs.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_DUMMY = 3'd1,
      S_ALIGN = 3'd2,
      S_STEAL = 3'd3,
      S_READ  = 3'd4,
      S_WRITE = 3'd5
   } sdma_state_e;
endpackage

// File: rtl/sdma_phase.sv
module sdma_phase (
   input  logic clk,
   input  logic rst_n,
   output logic phase_odd
);
   logic ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= 1'b0;
      else        ph_q <= ~ph_q;
   end

   assign phase_odd = ph_q;

   a_r1_phase_flips: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (phase_odd != $past(phase_odd)));
endmodule

// File: rtl/sdma_snoop.sv
module sdma_snoop #(
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              busy,
   output logic              trig
);
   assign trig = cpu_we && (cpu_addr == TRIG_ADDR) && !busy;
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
   import sdma_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int XFER_LEN  = 256,
   parameter int STEAL_CYC = 2,
   localparam int IDX_W    = $clog2(XFER_LEN),
   localparam int PAGE_W   = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              phase_odd,
   input  logic              smp_req,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              spr_we,
   output logic [IDX_W-1:0]  spr_idx,
   output logic [DATA_W-1:0] spr_wdata,
   output logic              cpu_halt,
   output logic              xfer_done,
   output logic              smp_gnt
);
   localparam int STL_W = (STEAL_CYC > 1) ? $clog2(STEAL_CYC) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(XFER_LEN - 1);
   localparam logic [STL_W-1:0] STL_END  = STL_W'((STEAL_CYC > 0) ? STEAL_CYC - 1 : 0);

   sdma_state_e       state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [PAGE_W-1:0] page_q;
   logic              odd_q;
   logic [STL_W-1:0]  stl_q;
   logic              done_q;
   logic              go_steal;
   sdma_state_e       to_read;

   generate
      if (STEAL_CYC > 0) begin : g_steal_on
         assign go_steal = smp_req;
      end else begin : g_steal_off
         assign go_steal = 1'b0;
      end
   endgenerate

   assign to_read = go_steal ? S_STEAL : S_READ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         page_q  <= '0;
         odd_q   <= 1'b0;
         stl_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (trig) begin
                  page_q  <= cpu_wdata[PAGE_W-1:0];
                  odd_q   <= phase_odd;
                  idx_q   <= '0;
                  state_q <= S_DUMMY;
               end
            end
            S_DUMMY: begin
               stl_q   <= '0;
               state_q <= odd_q ? S_ALIGN : to_read;
            end
            S_ALIGN: begin
               stl_q   <= '0;
               state_q <= to_read;
            end
            S_STEAL: begin
               stl_q <= stl_q + 1'b1;
               if (stl_q == STL_END) state_q <= S_READ;
            end
            S_READ: state_q <= S_WRITE;
            S_WRITE: begin
               stl_q <= '0;
               if (idx_q == LAST_IDX) begin
                  state_q <= S_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= to_read;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign cpu_halt  = (state_q != S_IDLE);
   assign mem_rd    = (state_q == S_READ);
   assign mem_addr  = {page_q, idx_q};
   assign spr_we    = (state_q == S_WRITE);
   assign spr_idx   = idx_q;
   assign spr_wdata = mem_rdata;
   assign smp_gnt   = (state_q == S_STEAL);
   assign xfer_done = done_q;

   a_r5_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> spr_we);
   a_r5_dead_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_halt) |-> !mem_rd && !spr_we);
   a_r6_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> !cpu_halt && $past(cpu_halt));
   a_r7_grant_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
      smp_gnt |-> cpu_halt);
   a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_halt |-> !mem_rd && !spr_we);
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine #(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter int                XFER_LEN  = 256,
   parameter int                STEAL_CYC = 2,
   parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
   localparam int               IDX_W     = $clog2(XFER_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              spr_we,
   output logic [IDX_W-1:0]  spr_idx,
   output logic [DATA_W-1:0] spr_wdata,
   output logic              cpu_halt,
   output logic              xfer_done,
   input  logic              smp_req,
   output logic              smp_gnt,
   output logic              phase_odd
);
   generate
      if ((XFER_LEN < 2) || ((XFER_LEN & (XFER_LEN - 1)) != 0)) begin : g_bad_len
         $error("XFER_LEN must be a power of two of at least 2");
      end
      if ((ADDR_W - IDX_W) != DATA_W) begin : g_bad_page
         $error("page field width must equal DATA_W");
      end
   endgenerate

   logic trig;

   sdma_phase u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_odd (phase_odd)
   );

   sdma_snoop #(.ADDR_W(ADDR_W), .TRIG_ADDR(TRIG_ADDR)) u_snoop (
      .cpu_we   (cpu_we),
      .cpu_addr (cpu_addr),
      .busy     (cpu_halt),
      .trig     (trig)
   );

   sdma_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XFER_LEN(XFER_LEN), .STEAL_CYC(STEAL_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (trig),
      .cpu_wdata (cpu_wdata),
      .phase_odd (phase_odd),
      .smp_req   (smp_req),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .spr_we    (spr_we),
      .spr_idx   (spr_idx),
      .spr_wdata (spr_wdata),
      .cpu_halt  (cpu_halt),
      .xfer_done (xfer_done),
      .smp_gnt   (smp_gnt)
   );

   a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_halt && cpu_we && cpu_addr == TRIG_ADDR) |=> $stable(mem_addr[ADDR_W-1:IDX_W]));
endmodule

// File: tb/tb_sdma_engine.sv
module tb_sdma_engine;
   localparam int CLK_P = 10;
   localparam logic [15:0] TRIG = 16'h4014;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_we = 1'b0;
   logic [15:0] mem_addr;
   logic        mem_rd;
   logic [7:0]  mem_rdata = '0;
   logic        spr_we;
   logic [7:0]  spr_idx;
   logic [7:0]  spr_wdata;
   logic        cpu_halt, xfer_done, smp_gnt, phase_odd;
   logic        smp_req = 1'b0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [7:0] exp_page = '0;
   int exp_idx = 0;

   always #(CLK_P/2) clk = ~clk;

   sdma_engine dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_we(cpu_we), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
      .spr_we(spr_we), .spr_idx(spr_idx), .spr_wdata(spr_wdata), .cpu_halt(cpu_halt),
      .xfer_done(xfer_done), .smp_req(smp_req), .smp_gnt(smp_gnt), .phase_odd(phase_odd)
   );

   function automatic logic [7:0] fmem(input logic [15:0] a);
      return a[7:0] ^ (a[15:8] * 8'd37) ^ 8'h5A;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // source memory: synchronous read, data the cycle after mem_rd
   always_ff @(posedge clk) if (mem_rd) mem_rdata <= fmem(mem_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // access monitor (R5, R10)
   always @(negedge clk) begin
      if (rst_n) begin
         if ((mem_rd || spr_we) && !cpu_halt)
            check(1'b0, "R10 access outside halt", 1, 0);
         if (mem_rd)
            check(mem_addr == {exp_page, exp_idx[7:0]}, "R5 read address",
                  int'(mem_addr), int'({exp_page, exp_idx[7:0]}));
         if (spr_we) begin
            check(spr_idx == exp_idx[7:0], "R5 write index", int'(spr_idx), exp_idx);
            check(spr_wdata == fmem({exp_page, exp_idx[7:0]}), "R5 write data",
                  int'(spr_wdata), int'(fmem({exp_page, exp_idx[7:0]})));
            exp_idx++;
         end
      end
   end

   task automatic do_xfer(input logic [7:0] pg, input bit odd, input int nst, input bit poke);
      int hcnt = 0;
      int served = 0;
      bit req_on = 0;
      int k1 = 3 + int'($urandom_range(0, 200));
      int k2 = k1 + 20 + int'($urandom_range(0, 200));
      while ((cyc % 2) != int'(odd)) @(negedge clk);
      exp_page = pg;
      exp_idx = 0;
      cpu_addr = TRIG; cpu_wdata = pg; cpu_we = 1'b1;
      @(negedge clk);
      cpu_we = 1'b0;
      check(cpu_halt == 1'b1, "R3 halt rises after trigger", int'(cpu_halt), 1);
      while (1) begin
         if (cpu_halt) hcnt++;
         else break;
         if (req_on && smp_gnt) begin
            req_on = 0; smp_req = 1'b0; served++;
         end else if (!req_on && served < nst &&
                      ((served == 0 && hcnt >= k1) || (served == 1 && hcnt >= k2))) begin
            req_on = 1; smp_req = 1'b1;
         end
         if (poke && hcnt == 100) begin
            cpu_addr = TRIG; cpu_wdata = ~pg; cpu_we = 1'b1;
         end else cpu_we = 1'b0;
         if (hcnt > 2000) break;
         @(negedge clk);
      end
      smp_req = 1'b0;
      cpu_we = 1'b0;
      check(served == nst, "R7 grants served", served, nst);
      if (odd) check(hcnt == 514 + 2*nst, "R4 odd stall length", hcnt, 514 + 2*nst);
      else     check(hcnt == 513 + 2*nst, "R3 even stall length", hcnt, 513 + 2*nst);
      check(exp_idx == 256, "R5 byte count", exp_idx, 256);
      check(xfer_done == 1'b1, "R6 done at release", int'(xfer_done), 1);
      @(negedge clk);
      check(xfer_done == 1'b0, "R6 done one cycle", int'(xfer_done), 0);
      if (poke) begin
         repeat (3) begin
            check(cpu_halt == 1'b0, "R9 no restart after busy write", int'(cpu_halt), 0);
            @(negedge clk);
         end
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check(cpu_halt == 1'b0 && xfer_done == 1'b0 && smp_gnt == 1'b0,
            "R3 reset state", int'({cpu_halt, xfer_done, smp_gnt}), 0);
      rst_n = 1'b1;
      // R1: phase follows the cycle count from release
      for (int i = 0; i < 6; i++) begin
         check(phase_odd == cyc[0], "R1 phase", int'(phase_odd), cyc % 2);
         @(negedge clk);
      end
      // R2: non-trigger address
      cpu_addr = 16'h4015; cpu_wdata = 8'h03; cpu_we = 1'b1;
      @(negedge clk);
      cpu_we = 1'b0;
      repeat (3) begin
         check(cpu_halt == 1'b0, "R2 other address ignored", int'(cpu_halt), 0);
         @(negedge clk);
      end
      // R8: idle sample request
      smp_req = 1'b1;
      repeat (4) begin
         @(negedge clk);
         check(smp_gnt == 1'b0 && cpu_halt == 1'b0, "R8 idle request ignored",
               int'({smp_gnt, cpu_halt}), 0);
      end
      smp_req = 1'b0;
      // directed corners
      do_xfer(8'h00, 1'b0, 0, 1'b0);
      do_xfer(8'hFF, 1'b1, 0, 1'b0);
      do_xfer(8'h12, 1'b1, 2, 1'b1);
      do_xfer(8'h80, 1'b0, 1, 1'b1);
      // random mix
      for (int n = 0; n < 8; n++) begin
         do_xfer(8'($urandom), 1'($urandom), int'($urandom_range(0, 2)), 1'($urandom));
         repeat (int'($urandom_range(0, 5))) @(negedge clk);
      end
      for (int i = 0; i < 4; i++) begin
         check(phase_odd == cyc[0], "R1 phase late", int'(phase_odd), cyc % 2);
         @(negedge clk);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule